// File: doc/BRIEF.md
# Dual PWM Action Qualifier with Continuous Force

This block turns time-base events into two PWM waveforms, `pwm_a` and `pwm_b`. Each output has its own event-to-action word. The word gives a 2-bit action for the zero strobe, the period strobe, an up-counting match against compare A and an up-counting match against compare B. When several events land on the same tick, one of them wins under a fixed priority. The block does not contain the counter. It watches the counter value, the direction flag and the zero and period strobes, and it updates its outputs only in cycles where the time-base `tick` enable is high.

A continuous software force can pin either output low or high and overrides the action table. The force request sits in a shadow field. It reaches the active copy at a point chosen by a 2-bit reload mode: on the zero event, on the period event, on either, or on every tick. A loaded force takes effect on the very tick that loads it.

A normal-polarity waveform uses zero=high, period=high and compare-up=low. An inverted waveform swaps high and low in those codes. Polarity is therefore only a matter of how the table is programmed.

Top module: `pwm_action_qualifier`

## Requirements
- R1: While reset (`rst_n` low) is applied and after it is released, both outputs are low and no force is active.
- R2: The outputs change only at a clock edge where `tick` is high. With `tick` low, events, actions and force requests leave both outputs unchanged.
- R3: The 2-bit action codes are 00 = hold, 01 = drive low, 10 = drive high and 11 = toggle. The new level appears one clock after the edge that samples the tick.
- R4: In each action word, bits [1:0] hold the zero action, [3:2] the period action, [5:4] the compare-A-up action and [9:8] the compare-B-up action. Bits [7:6] and [15:10] are ignored. Either output may react to either compare.
- R5: A compare event occurs only when `cnt_up` is 1 and `cnt` equals the compare value (`cmp_a` for compare A, `cmp_b` for compare B). An equal count while counting down is no event.
- R6: When several events coincide, the first event with a nonzero code in the order compare A, compare B, period, zero sets the action.
- R7: The force request `frc_sel` uses bits [1:0] for A and [3:2] for B. In each field, 01 forces low, 10 forces high, and 00 or 11 means no force. An active force overrides every table action.
- R8: The reload mode `frc_when` selects when `frc_sel` is copied to the active force: 00 on a ticked zero event, 01 on a ticked period event, 10 on either, 11 on every tick. A copied value governs the output on that same tick.
- R9: Between reloads, the active force holds its value, and changes to `frc_sel` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base tick enable |
| cnt | input | 16 | Counter value |
| cnt_up | input | 1 | 1 while the counter counts up |
| zero_evt | input | 1 | Counter-at-zero strobe |
| prd_evt | input | 1 | Counter-at-period strobe |
| cmp_a | input | 16 | Compare value A |
| cmp_b | input | 16 | Compare value B |
| act_a | input | 16 | Event-to-action word for output A |
| act_b | input | 16 | Event-to-action word for output B |
| frc_sel | input | 4 | Continuous force request, A in [1:0], B in [3:2] |
| frc_when | input | 2 | Force reload mode |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
The bench presents a compare match while counting down. A design that ignored direction would switch the output at that point. It stacks zero and compare events on one tick with conflicting codes, which shows whether the priority is reversed. It changes the force request between reload events, which shows whether a design applies it without waiting for the shadow load, or loads it on the wrong event or a tick late. It also sets the ignored action bits and uses the 11 force code, which a design decoding either one wrongly would turn into spurious level changes.

// File: rtl/pwm_action_qualifier.sv
module pwm_action_qualifier #(
  parameter int CW = 16,
  parameter int NCH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  input  logic          cnt_up,
  input  logic          zero_evt,
  input  logic          prd_evt,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  input  logic [15:0]   act_a,
  input  logic [15:0]   act_b,
  input  logic [3:0]    frc_sel,
  input  logic [1:0]    frc_when,
  output logic          pwm_a,
  output logic          pwm_b
);
  localparam int FW = 2 * NCH;

  logic [FW-1:0]  frc_held, frc_eff;
  logic [NCH-1:0] lvl;
  logic           hit_a, hit_b, reload;
  logic [15:0]    act [NCH];

  assign hit_a = cnt_up && (cnt == cmp_a);
  assign hit_b = cnt_up && (cnt == cmp_b);
  assign act[0] = act_a;
  assign act[1] = act_b;

  always_comb begin
    unique case (frc_when)
      2'b00:   reload = tick && zero_evt;
      2'b01:   reload = tick && prd_evt;
      2'b10:   reload = tick && (zero_evt || prd_evt);
      default: reload = tick;
    endcase
  end

  assign frc_eff = reload ? frc_sel : frc_held;

  always_ff @(posedge clk) begin
    if (!rst_n) frc_held <= '0;
    else if (reload) frc_held <= frc_sel;
  end

  function automatic logic [1:0] pick(input logic [15:0] w, input logic ca,
                                      input logic cb, input logic pr, input logic zr);
    if (ca && w[5:4] != 2'b00)      pick = w[5:4];
    else if (cb && w[9:8] != 2'b00) pick = w[9:8];
    else if (pr && w[3:2] != 2'b00) pick = w[3:2];
    else if (zr)                    pick = w[1:0];
    else                            pick = 2'b00;
  endfunction

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [1:0] code, fc;
    logic       nxt;
    assign code = pick(act[i], hit_a, hit_b, prd_evt, zero_evt);
    assign fc   = frc_eff[2*i +: 2];
    always_comb begin
      unique case (fc)
        2'b01: nxt = 1'b0;
        2'b10: nxt = 1'b1;
        default: begin
          unique case (code)
            2'b01:   nxt = 1'b0;
            2'b10:   nxt = 1'b1;
            2'b11:   nxt = ~lvl[i];
            default: nxt = lvl[i];
          endcase
        end
      endcase
    end
    always_ff @(posedge clk) begin
      if (!rst_n) lvl[i] <= 1'b0;
      else if (tick) lvl[i] <= nxt;
    end
  end

  assign pwm_a = lvl[0];
  assign pwm_b = lvl[1];
endmodule

// File: rtl/pwm_aq_checker.sv
module pwm_aq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic [15:0] cnt,
  input logic        cnt_up,
  input logic        zero_evt,
  input logic        prd_evt,
  input logic [15:0] cmp_a,
  input logic [15:0] cmp_b,
  input logic [15:0] act_a,
  input logic [3:0]  frc_sel,
  input logic [1:0]  frc_when,
  input logic        pwm_a,
  input logic        pwm_b
);
  a_r1_reset_low: assert property (@(posedge clk) !rst_n |=> (!pwm_a && !pwm_b));

  a_r2_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(pwm_a) && $stable(pwm_b)));

  a_r7_force_low_a: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frc_when == 2'b11 && frc_sel[1:0] == 2'b01) |=> !pwm_a);

  a_r7_force_high_b: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frc_when == 2'b11 && frc_sel[3:2] == 2'b10) |=> pwm_b);

  a_r3_zero_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frc_when == 2'b11 && (frc_sel[1:0] == 2'b00 || frc_sel[1:0] == 2'b11)
     && zero_evt && !prd_evt && cnt != cmp_a && cnt != cmp_b && act_a[1:0] == 2'b10)
    |=> pwm_a);

  a_r3_zero_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frc_when == 2'b11 && (frc_sel[1:0] == 2'b00 || frc_sel[1:0] == 2'b11)
     && zero_evt && !prd_evt && !cnt_up && act_a[1:0] == 2'b11)
    |=> (pwm_a != $past(pwm_a)));
endmodule

bind pwm_action_qualifier pwm_aq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cnt_up(cnt_up),
  .zero_evt(zero_evt), .prd_evt(prd_evt), .cmp_a(cmp_a), .cmp_b(cmp_b),
  .act_a(act_a), .frc_sel(frc_sel), .frc_when(frc_when),
  .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/tb_pwm_action_qualifier.sv
module tb_pwm_action_qualifier;
  logic        clk = 0, rst_n = 0, tick = 0, cnt_up = 1, zero_evt = 0, prd_evt = 0;
  logic [15:0] cnt = 0, cmp_a = 5, cmp_b = 9, act_a = 0, act_b = 0;
  logic [3:0]  frc_sel = 0;
  logic [1:0]  frc_when = 0;
  logic        pwm_a, pwm_b;
  int n_chk = 0, n_bad = 0;
  logic        m_a = 0, m_b = 0;
  logic [3:0]  m_frc = 0;

  always #2 clk = ~clk;

  pwm_action_qualifier dut (.*);

  function automatic logic apply(input logic cur, input logic [1:0] c);
    case (c) 2'b01: return 1'b0; 2'b10: return 1'b1; 2'b11: return ~cur; default: return cur; endcase
  endfunction

  function automatic logic [1:0] sel_code(input logic [15:0] w, input logic ca, input logic cb,
                                          input logic pr, input logic zr);
    logic [1:0] r = 2'b00;
    if (zr) r = w[1:0];
    if (pr && w[3:2] != 0) r = w[3:2];
    if (cb && w[9:8] != 0) r = w[9:8];
    if (ca && w[5:4] != 0) r = w[5:4];
    return r;
  endfunction

  function automatic logic step_out(input logic cur, input logic [1:0] f, input logic [1:0] c);
    if (f == 2'b01) return 1'b0;
    if (f == 2'b10) return 1'b1;
    return apply(cur, c);
  endfunction

  always @(posedge clk) begin
    logic ld, ca, cb;
    logic [3:0] f;
    if (!rst_n) begin
      m_a <= 0; m_b <= 0; m_frc <= 0;
    end else if (tick) begin
      ld = (frc_when == 2'b11) || (frc_when == 2'b00 && zero_evt) ||
           (frc_when == 2'b01 && prd_evt) || (frc_when == 2'b10 && (zero_evt || prd_evt));
      f  = ld ? frc_sel : m_frc;
      ca = cnt_up && cnt == cmp_a;
      cb = cnt_up && cnt == cmp_b;
      m_frc <= f;
      m_a <= step_out(m_a, f[1:0], sel_code(act_a, ca, cb, prd_evt, zero_evt));
      m_b <= step_out(m_b, f[3:2], sel_code(act_b, ca, cb, prd_evt, zero_evt));
    end
  end

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic run(input logic t, input logic z, input logic p, input logic up, input logic [15:0] c);
    tick = t; zero_evt = z; prd_evt = p; cnt_up = up; cnt = c;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    chk("R1 reset a", pwm_a, 0); chk("R1 reset b", pwm_b, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", pwm_a, 0);
    act_a = 16'h0002; run(1, 1, 0, 1, 0); chk("R4 zero field high", pwm_a, 1);
    act_a = 16'h0001; run(0, 1, 0, 1, 0); chk("R2 no tick holds", pwm_a, 1);
    act_a = 16'h000C; run(1, 0, 1, 1, 3); chk("R3 toggle to low", pwm_a, 0);
    run(1, 0, 1, 1, 3); chk("R3 toggle to high", pwm_a, 1);
    act_a = 16'h0010; run(1, 0, 0, 0, 5); chk("R5 down match ignored", pwm_a, 1);
    run(1, 0, 0, 1, 5); chk("R5 up match low", pwm_a, 0);
    act_a = 16'h0021; run(1, 1, 0, 1, 5); chk("R6 compare over zero high", pwm_a, 1);
    act_a = 16'h0012; run(1, 1, 0, 1, 5); chk("R6 compare over zero low", pwm_a, 0);
    act_a = 16'hFCC0; run(1, 1, 1, 1, 5); chk("R4 ignored bits", pwm_a, 0);
    chk("R4 other output untouched", pwm_b, 0);
    act_a = 16'h0200; run(1, 0, 0, 1, 9); chk("R4 compare B field", pwm_a, 1);
    act_a = 16'h0005; frc_sel = 4'b0010; frc_when = 2'b00;
    run(1, 0, 1, 1, 3); chk("R9 shadow not loaded", pwm_a, 0);
    run(1, 1, 0, 1, 0); chk("R8 load on zero", pwm_a, 1);
    frc_sel = 4'b0000; run(1, 0, 1, 1, 3); chk("R9 held force", pwm_a, 1);
    frc_when = 2'b01; run(1, 1, 0, 1, 0); chk("R8 period mode ignores zero", pwm_a, 1);
    run(1, 0, 1, 1, 3); chk("R8 load on period", pwm_a, 0);
    frc_when = 2'b11; frc_sel = 4'b1000; run(1, 0, 0, 1, 1); chk("R8 immediate force", pwm_b, 1);
    frc_sel = 4'b1100; act_b = 16'h0001; run(1, 1, 0, 1, 0); chk("R7 code 11 no force", pwm_b, 0);
    act_a = 16'h0002; frc_sel = 4'b0001; run(1, 1, 0, 1, 0); chk("R7 force low overrides", pwm_a, 0);
    for (int k = 0; k < 1500; k++) begin
      tick = ($urandom % 4) != 0;
      zero_evt = ($urandom % 3) == 0;
      prd_evt = ($urandom % 3) == 0;
      cnt_up = $urandom % 2;
      cnt = 16'($urandom % 4);
      if ($urandom % 8 == 0) begin cmp_a = 16'($urandom % 4); cmp_b = 16'($urandom % 4); end
      if ($urandom % 6 == 0) begin act_a = 16'($urandom); act_b = 16'($urandom); end
      if ($urandom % 5 == 0) frc_sel = 4'($urandom);
      if ($urandom % 20 == 0) frc_when = 2'($urandom);
      @(negedge clk);
      chk("R3 R6 R8 random a", pwm_a, m_a);
      chk("R3 R6 R8 random b", pwm_b, m_b);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule